// File: doc/BRIEF.md
# Stop-Mode Entry and Wake Controller

This block runs the deepest power-saving state of a small 8-bit microcontroller. When the core executes its stop instruction, the block gates the CPU and peripheral clocks and switches off both the pin oscillator and the internal low-power oscillator. In the same step it sends one-cycle strobes to the peripheral registers. These strobes clear the core-timer flags and enables and the programmable-timer flags and enables. They also set the external interrupt enable and clear the CPU global interrupt mask.

While stopped, the block watches the active-low external interrupt pin and, when the port-interrupt option is on, four port pins. A falling edge on an enabled source restarts the oscillators. The clocks stay gated for a settle period, and then the block releases the clocks and asks the core to fetch the external interrupt vector. Pin sampling and edge detection run on a free-running always-on clock, so wake detection works while every other clock is off.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset the clock enable and both oscillator enables are 1, and all entry strobes and the vector request are 0.
- R2: A stop request seen while running drops the clock enable and both oscillator enables from the next cycle on, and they stay low until a wake event.
- R3: The four entry strobes (core-timer clear, programmable-timer clear, external interrupt enable set, global mask clear) are 1 together for exactly one cycle after a stop request accepted while running. They are 0 at all other times, including when a stop request arrives while stopped or settling.
- R4: While stopped, a 1-to-0 transition on the external interrupt pin wakes the block. A 0-to-1 transition does not wake it, and neither does a pin that was already low when stop was entered.
- R5: A 1-to-0 transition on any of the four port pins wakes the block only when the port wake option input is 1. With the option at 0, port pin activity leaves the block stopped.
- R6: The wake pins pass through a two-flop synchroniser. When a pin falls between two clock edges, the oscillator enables rise after the third following rising edge.
- R7: After a wake event, the oscillator enables are 1 and the clock enable stays 0 for exactly SETTLE_CYCLES cycles (default 4064). Then the clock enable returns to 1.
- R8: In the first cycle with the clock enable back at 1, the vector request is 1 for one cycle and the vector address output is 0x1FFA, the high-byte location of the external interrupt vector, with the low byte at 0x1FFB. At all other times the address output is 0.
- R9: Edges on the wake pins while running cause no state change, no strobe and no vector request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aonClk | input | 1 | Free-running always-on clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReq | input | 1 | Core executes the stop instruction (one-cycle pulse) |
| irqPinN | input | 1 | External interrupt pin, active low, asynchronous |
| portPinsN | input | 4 | Port pins usable as wake sources, active low, asynchronous |
| portWakeEn | input | 1 | Option bit that allows port pins to wake the block |
| clkEn | output | 1 | Enable for the CPU and all internal peripheral clocks |
| extOscEn | output | 1 | Enable for the pin oscillator |
| lpOscEn | output | 1 | Enable for the internal low-power oscillator |
| clrCoreTmr | output | 1 | Strobe that clears the core-timer flags and enables |
| clrProgTmr | output | 1 | Strobe that clears the programmable-timer flags and enables |
| setIrqEnable | output | 1 | Strobe that sets the external interrupt enable |
| clrIntMask | output | 1 | Strobe that clears the CPU global interrupt mask |
| wakeVecReq | output | 1 | One-cycle request to fetch the external interrupt vector |
| wakeVecAddr | output | 16 | Vector high-byte address while the request is 1, else 0 |

## Verification
The controller state shows up directly on the clock and oscillator enables, so a wrong state appears at the ports in the cycle after it occurs. A synchroniser or edge detector with the wrong depth or polarity shifts the oscillator turn-on by a countable number of cycles, or wakes on the wrong pin transition. A settle counter that is off by one changes how many cycles the oscillators run while the clocks are still gated, and the bench counts this exactly. A strobe held too long, or fired from the wrong state, shows up on the strobe pins one cycle after a stop request.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAKE = 2'd2
  } swcState_t;

  typedef struct packed {
    logic enterStop;   // accept stop this cycle
    logic loadDelay;   // start settle countdown
    logic releaseCore; // settle done, return to run
  } swcStrobes_t;
endpackage

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int PORT_PINS     = 4,
  parameter int SETTLE_CYCLES = 4064,
  parameter logic [15:0] VEC_ADDR = 16'h1FFA
) (
  input  logic                 aonClk,
  input  logic                 rstN,
  input  logic                 irqPinN,
  input  logic [PORT_PINS-1:0] portPinsN,
  input  logic                 portWakeEn,
  input  swcStrobes_t          ctl,
  output logic                 wakeEvent,
  output logic                 delayDone,
  output logic                 entryPulse,
  output logic                 vecPulse,
  output logic [15:0]          vecAddr
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam int SRC_N = PORT_PINS + 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  logic [SRC_N-1:0] rawPins;
  logic [SRC_N-1:0] syncA, syncB, prevB, srcFall;
  logic [CNT_W-1:0] settleCnt;

  assign rawPins = {portPinsN, irqPinN};

  genvar g;
  generate
    for (g = 0; g < SRC_N; g++) begin : g_src
      always_ff @(posedge aonClk or negedge rstN) begin
        if (!rstN) begin
          syncA[g] <= 1'b1;
          syncB[g] <= 1'b1;
          prevB[g] <= 1'b1;
        end else begin
          syncA[g] <= rawPins[g];
          syncB[g] <= syncA[g];
          prevB[g] <= syncB[g];
        end
      end
      assign srcFall[g] = prevB[g] & ~syncB[g];
    end
  endgenerate

  assign wakeEvent = srcFall[0] | (portWakeEn & (|srcFall[SRC_N-1:1]));

  always_ff @(posedge aonClk or negedge rstN) begin
    if (!rstN)               settleCnt <= '0;
    else if (ctl.loadDelay)  settleCnt <= CNT_LOAD;
    else if (settleCnt != 0) settleCnt <= settleCnt - 1'b1;
  end
  assign delayDone = (settleCnt == 0);

  always_ff @(posedge aonClk or negedge rstN) begin
    if (!rstN) begin
      entryPulse <= 1'b0;
      vecPulse   <= 1'b0;
    end else begin
      entryPulse <= ctl.enterStop;
      vecPulse   <= ctl.releaseCore;
    end
  end
  assign vecAddr = vecPulse ? VEC_ADDR : 16'h0000;

  a_r3_entry_one_cycle: assert property (@(posedge aonClk) disable iff (!rstN)
    entryPulse |=> !entryPulse);
  a_r8_vec_one_cycle: assert property (@(posedge aonClk) disable iff (!rstN)
    vecPulse |=> !vecPulse);
  a_r7_count_down: assert property (@(posedge aonClk) disable iff (!rstN)
    (settleCnt != 0 && !ctl.loadDelay) |=> settleCnt == $past(settleCnt) - 1'b1);
  a_r7_load_value: assert property (@(posedge aonClk) disable iff (!rstN)
    ctl.loadDelay |=> settleCnt == CNT_LOAD);
endmodule

// File: rtl/swc_control.sv
module swc_control
  import swc_pkg::*;
(
  input  logic        aonClk,
  input  logic        rstN,
  input  logic        stopReq,
  input  logic        wakeEvent,
  input  logic        delayDone,
  output swcStrobes_t ctl,
  output logic        clkEn,
  output logic        oscEn
);
  swcState_t state, nextState;

  always_comb begin
    nextState       = state;
    ctl             = '0;
    case (state)
      ST_RUN: if (stopReq) begin
        nextState     = ST_STOP;
        ctl.enterStop = 1'b1;
      end
      ST_STOP: if (wakeEvent) begin
        nextState     = ST_WAKE;
        ctl.loadDelay = 1'b1;
      end
      ST_WAKE: if (delayDone) begin
        nextState       = ST_RUN;
        ctl.releaseCore = 1'b1;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge aonClk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  assign clkEn = (state == ST_RUN);
  assign oscEn = (state != ST_STOP);

  a_r2_stop_from_run: assert property (@(posedge aonClk) disable iff (!rstN)
    (state == ST_STOP && $past(state) != ST_STOP) |-> ($past(stopReq) && $past(state) == ST_RUN));
  a_r4_wake_needs_event: assert property (@(posedge aonClk) disable iff (!rstN)
    (state == ST_WAKE && $past(state) == ST_STOP) |-> $past(wakeEvent));
  a_r7_run_after_settle: assert property (@(posedge aonClk) disable iff (!rstN)
    (state == ST_RUN && $past(state) == ST_WAKE) |-> $past(delayDone));
  a_r9_run_ignores_wake: assert property (@(posedge aonClk) disable iff (!rstN)
    (state == ST_RUN && !stopReq) |=> state == ST_RUN);
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int PORT_PINS     = 4,
  parameter int SETTLE_CYCLES = 4064,
  parameter logic [15:0] VEC_ADDR = 16'h1FFA
) (
  input  logic                 aonClk,
  input  logic                 rstN,
  input  logic                 stopReq,
  input  logic                 irqPinN,
  input  logic [PORT_PINS-1:0] portPinsN,
  input  logic                 portWakeEn,
  output logic                 clkEn,
  output logic                 extOscEn,
  output logic                 lpOscEn,
  output logic                 clrCoreTmr,
  output logic                 clrProgTmr,
  output logic                 setIrqEnable,
  output logic                 clrIntMask,
  output logic                 wakeVecReq,
  output logic [15:0]          wakeVecAddr
);
  swcStrobes_t ctl;
  logic wakeEvent, delayDone, entryPulse, oscEn;

  swc_control u_control (
    .aonClk    (aonClk),
    .rstN      (rstN),
    .stopReq   (stopReq),
    .wakeEvent (wakeEvent),
    .delayDone (delayDone),
    .ctl       (ctl),
    .clkEn     (clkEn),
    .oscEn     (oscEn)
  );

  swc_datapath #(
    .PORT_PINS     (PORT_PINS),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .VEC_ADDR      (VEC_ADDR)
  ) u_datapath (
    .aonClk     (aonClk),
    .rstN       (rstN),
    .irqPinN    (irqPinN),
    .portPinsN  (portPinsN),
    .portWakeEn (portWakeEn),
    .ctl        (ctl),
    .wakeEvent  (wakeEvent),
    .delayDone  (delayDone),
    .entryPulse (entryPulse),
    .vecPulse   (wakeVecReq),
    .vecAddr    (wakeVecAddr)
  );

  assign extOscEn     = oscEn;
  assign lpOscEn      = oscEn;
  assign clrCoreTmr   = entryPulse;
  assign clrProgTmr   = entryPulse;
  assign setIrqEnable = entryPulse;
  assign clrIntMask   = entryPulse;

  a_r3_strobes_in_stop: assert property (@(posedge aonClk) disable iff (!rstN)
    clrCoreTmr |-> (!clkEn && !extOscEn));
  a_r8_vec_with_clock: assert property (@(posedge aonClk) disable iff (!rstN)
    wakeVecReq |-> (clkEn && $past(!clkEn)));
endmodule

// File: tb/test_stop_wake_ctrl.sv
module test_stop_wake_ctrl;
  localparam int SETTLE = 16;

  logic aonClk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0;
  logic irqPinN = 1'b1;
  logic [3:0] portPinsN = 4'hF;
  logic portWakeEn = 1'b0;
  logic clkEn, extOscEn, lpOscEn, clrCoreTmr, clrProgTmr, setIrqEnable, clrIntMask, wakeVecReq;
  logic [15:0] wakeVecAddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 aonClk = ~aonClk;

  stop_wake_ctrl #(.SETTLE_CYCLES(SETTLE)) i_stop_wake_ctrl (
    .aonClk(aonClk), .rstN(rstN), .stopReq(stopReq), .irqPinN(irqPinN),
    .portPinsN(portPinsN), .portWakeEn(portWakeEn), .clkEn(clkEn),
    .extOscEn(extOscEn), .lpOscEn(lpOscEn), .clrCoreTmr(clrCoreTmr),
    .clrProgTmr(clrProgTmr), .setIrqEnable(setIrqEnable), .clrIntMask(clrIntMask),
    .wakeVecReq(wakeVecReq), .wakeVecAddr(wakeVecAddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {clrCoreTmr, clrProgTmr, setIrqEnable, clrIntMask};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge aonClk);
  endtask

  task automatic doStop();
    @(negedge aonClk) stopReq = 1'b1;
    @(negedge aonClk) stopReq = 1'b0;
    chk("R3 strobes on entry", strobes(), 4'hF);
    chk("R2 gated after stop", {clkEn, extOscEn, lpOscEn}, 3'b000);
    @(negedge aonClk);
    chk("R3 strobes one cycle", strobes(), 4'h0);
    chk("R2 still stopped", {clkEn, extOscEn}, 2'b00);
  endtask

  // {source: 0 irq / 1 port, port bit, option bit, expect wake}
  localparam logic [4:0] VECS [6] = '{
    {1'b0, 2'd0, 1'b0, 1'b1},
    {1'b0, 2'd0, 1'b1, 1'b1},
    {1'b1, 2'd0, 1'b0, 1'b0},
    {1'b1, 2'd3, 1'b0, 1'b0},
    {1'b1, 2'd1, 1'b1, 1'b1},
    {1'b1, 2'd3, 1'b1, 1'b1}
  };

  always @(posedge aonClk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nStop, nWake;
    idle(3);
    chk("R1 reset enables", {clkEn, extOscEn, lpOscEn}, 3'b111);
    chk("R1 reset strobes", {strobes(), wakeVecReq}, 5'h0);
    @(negedge aonClk) rstN = 1'b1;
    idle(2);
    chk("R1 after release", {clkEn, extOscEn, wakeVecReq}, 3'b110);

    // vector walk: R4, R5
    foreach (VECS[v]) begin
      logic [4:0] e;
      e = VECS[v];
      irqPinN = 1'b1; portPinsN = 4'hF; portWakeEn = e[1];
      doStop();
      @(negedge aonClk);
      if (e[4]) portPinsN[e[3:2]] = 1'b0; else irqPinN = 1'b0;
      idle(6);
      chk(e[4] ? "R5 port wake gating" : "R4 irq fall wakes", extOscEn, e[0]);
      if (!e[0]) begin
        portPinsN = 4'hF;
        idle(6);
        chk("R4 rising edge ignored", {clkEn, extOscEn}, 2'b00);
        irqPinN = 1'b0;
      end
      idle(SETTLE + 8);
      chk("R7 running after settle", clkEn, 1'b1);
      irqPinN = 1'b1; portPinsN = 4'hF;
      idle(4);
    end
    portWakeEn = 1'b0;

    // exact timing: R6, R7, R8
    doStop();
    @(negedge aonClk) irqPinN = 1'b0;
    nStop = 0; nWake = 0;
    @(negedge aonClk);
    while (!extOscEn && nStop < 50) begin nStop++; @(negedge aonClk); end
    while (extOscEn && !clkEn && nWake < 200) begin nWake++; @(negedge aonClk); end
    chk("R6 sync latency", nStop, 2);
    chk("R7 settle length", nWake, SETTLE);
    chk("R8 vector request", wakeVecReq, 1'b1);
    chk("R8 vector address", wakeVecAddr, 16'h1FFA);
    @(negedge aonClk);
    chk("R8 request one cycle", {wakeVecReq, wakeVecAddr}, 17'h0);
    irqPinN = 1'b1;
    idle(4);

    // R9: pin edges while running
    irqPinN = 1'b0; portWakeEn = 1'b1; portPinsN = 4'h0;
    for (int i = 0; i < 8; i++) begin
      @(negedge aonClk);
      if (wakeVecReq || strobes() != 0 || !clkEn) chk("R9 run ignores pins", 1, 0);
    end
    chk("R9 still running", {clkEn, extOscEn, wakeVecReq}, 3'b110);

    // R4: pin already low at entry does not wake
    portWakeEn = 1'b0; portPinsN = 4'hF;
    doStop();
    // R3: stop request while stopped is ignored
    @(negedge aonClk) stopReq = 1'b1;
    @(negedge aonClk) stopReq = 1'b0;
    chk("R3 no strobe when stopped", strobes(), 4'h0);
    idle(8);
    chk("R4 held-low pin ignored", extOscEn, 1'b0);
    irqPinN = 1'b1;
    idle(4);
    irqPinN = 1'b0;
    idle(5);
    // R3: stop request while settling is ignored
    @(negedge aonClk) stopReq = 1'b1;
    @(negedge aonClk) stopReq = 1'b0;
    chk("R3 no strobe when settling", {strobes(), extOscEn}, 5'h1);
    idle(SETTLE + 4);
    chk("R7 back to run", clkEn, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule